// File: doc/BRIEF.md
# Security-Aware Cache Policy Override Register

This block is a single coprocessor-style control register that holds six override bits for the cache. The bits form two groups of three: one group governs regions tagged Secure and the other governs regions tagged Non-secure. Each group has one bit that downgrades write-back to write-through, one that stops instruction-side allocation, and one that stops data-side allocation. A register access is claimed only when its four opcode and register-number fields match this register. The requester's security state and privilege then decide what it may see and change. An access that is not allowed raises an undefined-instruction flag.

A second, purely combinational path applies the stored bits to live traffic. For each instruction-side and data-side request it picks a group from that request's security tag. It then reports whether a data-side miss may allocate, whether an instruction-side miss may allocate, and the effective data-side region attribute. All pins are plain control signals. Register accesses are single-cycle and are never back-pressured, so no valid/ready handshake applies. A write is committed on the clock edge that ends its cycle, and read data is valid combinationally within the same cycle.

Top module: `cache_ovr_ctl`

## Requirements
- R1: The register is selected only when `acc_valid` is high and op1=0, crn=9, crm=8 and op2=0. With any other encoding, or with `acc_valid` low, `acc_hit` and `acc_undef` stay low, `acc_rdata` is zero and the stored bits do not change.
- R2: Reset clears all six stored bits. Afterwards every read returns zero, no linefill is blocked and data attributes pass through unchanged.
- R3: A Secure privileged access (`acc_secure`=1, `acc_priv`=1) reads all six bits and writes all six bits. A write becomes visible from the cycle after the edge that accepts it. A read returns the stored value in the same cycle and returns zero on a write cycle.
- R4: Bits above 5 always read as zero, and values written to them are discarded.
- R5: A Non-secure privileged read returns bits 2:0 and reads bits 5:3 as zero.
- R6: A Non-secure privileged write updates bits 2:0 and leaves bits 5:3 unchanged.
- R7: Any unprivileged access to the register, read or write, raises `acc_undef`, returns zero data and changes no stored bit.
- R8: Bit positions: bit 5 is Secure write-through force, bit 4 is Secure instruction-fill block and bit 3 is Secure data-fill block. Bits 2, 1 and 0 are the same three controls for Non-secure regions. Each request uses the group named by its own security tag.
- R9: Attribute encoding is 00 non-cacheable, 01 write-through, 10 write-back and 11 reserved. `d_attr_eff` is 01 when `d_attr` is 10 and the selected write-through bit is set. In every other case `d_attr_eff` equals `d_attr`.
- R10: `i_fill_block` is high only when `i_miss` is high and the selected instruction-fill bit is set. Hits are never affected.
- R11: `d_fill_block` is high only when `d_miss` is high, the selected data-fill bit is set and `d_attr` is 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_secure | input | 1 | Requester is in the Secure state |
| acc_priv | input | 1 | Requester is privileged |
| acc_wdata | input | 32 | Write data |
| acc_hit | output | 1 | Access decoded to this register |
| acc_rdata | output | 32 | Read data |
| acc_undef | output | 1 | Undefined-instruction exception request |
| i_secure | input | 1 | Security tag of the instruction-side request |
| i_miss | input | 1 | Instruction-side lookup missed |
| i_fill_block | output | 1 | Suppress instruction-side allocation |
| d_secure | input | 1 | Security tag of the data-side request |
| d_attr | input | 2 | Data-side region attribute |
| d_miss | input | 1 | Data-side lookup missed |
| d_attr_eff | output | 2 | Effective data-side region attribute |
| d_fill_block | output | 1 | Suppress data-side allocation |

## Verification
The in-line assertions check several rules on every cycle. An undefined access or an access that does not decode never disturbs the stored bits. A Non-secure write never touches the Secure group, and Non-secure reads always show zero there. Attributes other than write-back pass through untouched, and a fill is blocked only on a miss. Only the bench's scenarios show the exact stored values after each sequence of mixed-privilege writes. The same holds for the one-cycle visibility of a write, the clearing by a reset taken mid-run, and the full policy truth table under several register contents.

// File: rtl/cov_pkg.sv
package cov_pkg;
  localparam int GRP_W = 3;
  localparam int N_GRP = 2;
  localparam int CTL_W = GRP_W * N_GRP;
  localparam int GRP_NS = 0;
  localparam int GRP_S  = 1;

  typedef enum logic [1:0] {
    ATTR_NC  = 2'b00,
    ATTR_WT  = 2'b01,
    ATTR_WB  = 2'b10,
    ATTR_RSV = 2'b11
  } mem_attr_e;

  // member order fixes bit order: wt is the top bit of a group
  typedef struct packed {
    logic wt_force;
    logic ifill_off;
    logic dfill_off;
  } grp_t;
endpackage

// File: rtl/cov_decode.sv
module cov_decode #(
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP1_W-1:0] OP1_SEL = '0,
  parameter logic [CRN_W-1:0] CRN_SEL = 4'd9,
  parameter logic [CRM_W-1:0] CRM_SEL = 4'd8,
  parameter logic [OP2_W-1:0] OP2_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OP1_W-1:0] acc_op1,
  input  logic [CRN_W-1:0] acc_crn,
  input  logic [CRM_W-1:0] acc_crm,
  input  logic [OP2_W-1:0] acc_op2,
  input  logic             acc_secure,
  input  logic             acc_priv,
  output logic             hit,
  output logic             undef,
  output logic             rd_en,
  output logic             wen_ns,
  output logic             wen_s
);
  logic allowed;

  always_comb begin
    hit     = acc_valid && (acc_op1 == OP1_SEL) && (acc_crn == CRN_SEL)
              && (acc_crm == CRM_SEL) && (acc_op2 == OP2_SEL);
    undef   = hit && !acc_priv;
    allowed = hit && acc_priv;
    rd_en   = allowed && !acc_write;
    wen_ns  = allowed && acc_write;
    wen_s   = allowed && acc_write && acc_secure;
  end

  // R7
  undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !(wen_ns || wen_s || rd_en));

  // R6
  ns_no_secure_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_secure |-> !wen_s);
endmodule

// File: rtl/cov_store.sv
module cov_store
  import cov_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GRP-1:0]  wen,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTL_W-1:0]  ctl_q
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:CTL_W];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wen[g]) q <= wdata[g*GRP_W +: GRP_W];
    end
    assign ctl_q[g*GRP_W +: GRP_W] = q;
  end
endmodule

// File: rtl/cov_policy.sv
module cov_policy
  import cov_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             i_secure,
  input  logic             i_miss,
  input  logic             d_secure,
  input  mem_attr_e        d_attr,
  input  logic             d_miss,
  output logic             i_fill_block,
  output mem_attr_e        d_attr_eff,
  output logic             d_fill_block
);
  grp_t ig, dg;
  logic d_cacheable;

  always_comb begin
    ig = i_secure ? grp_t'(ctl_q[GRP_S*GRP_W +: GRP_W])
                  : grp_t'(ctl_q[GRP_NS*GRP_W +: GRP_W]);
    dg = d_secure ? grp_t'(ctl_q[GRP_S*GRP_W +: GRP_W])
                  : grp_t'(ctl_q[GRP_NS*GRP_W +: GRP_W]);
    d_cacheable  = (d_attr == ATTR_WT) || (d_attr == ATTR_WB);
    d_attr_eff   = (d_attr == ATTR_WB && dg.wt_force) ? ATTR_WT : d_attr;
    d_fill_block = d_miss && d_cacheable && dg.dfill_off;
    i_fill_block = i_miss && ig.ifill_off;
  end

  // R9
  non_wb_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_attr != ATTR_WB) |-> (d_attr_eff == d_attr));

  // R9
  wb_only_to_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_attr == ATTR_WB) |-> (d_attr_eff inside {ATTR_WB, ATTR_WT}));

  // R10
  ifill_miss_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_fill_block |-> i_miss);

  // R11
  dfill_miss_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_fill_block |-> (d_miss && d_attr != ATTR_NC));
endmodule

// File: rtl/cache_ovr_ctl.sv
module cache_ovr_ctl
  import cov_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic              acc_secure,
  input  logic              acc_priv,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_hit,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_undef,
  input  logic              i_secure,
  input  logic              i_miss,
  output logic              i_fill_block,
  input  logic              d_secure,
  input  logic [1:0]        d_attr,
  input  logic              d_miss,
  output logic [1:0]        d_attr_eff,
  output logic              d_fill_block
);
  logic             rd_en, wen_ns, wen_s;
  logic [N_GRP-1:0] wen;
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] vis;
  mem_attr_e        eff;

  cov_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_secure(acc_secure), .acc_priv(acc_priv),
    .hit(acc_hit), .undef(acc_undef), .rd_en(rd_en),
    .wen_ns(wen_ns), .wen_s(wen_s)
  );

  always_comb begin
    wen         = '0;
    wen[GRP_NS] = wen_ns;
    wen[GRP_S]  = wen_s;
  end

  cov_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wen(wen), .wdata(acc_wdata), .ctl_q(ctl_q)
  );

  always_comb begin
    vis = ctl_q;
    if (!acc_secure) vis[GRP_S*GRP_W +: GRP_W] = '0;
    acc_rdata = '0;
    if (rd_en) acc_rdata[CTL_W-1:0] = vis;
  end

  cov_policy u_pol (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q),
    .i_secure(i_secure), .i_miss(i_miss),
    .d_secure(d_secure), .d_attr(mem_attr_e'(d_attr)), .d_miss(d_miss),
    .i_fill_block(i_fill_block), .d_attr_eff(eff), .d_fill_block(d_fill_block)
  );
  assign d_attr_eff = eff;

  // R7
  undef_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> $stable(ctl_q));

  // R7
  undef_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> (acc_rdata == '0));

  // R1
  miss_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |=> $stable(ctl_q));

  // R1
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> (acc_rdata == '0 && !acc_undef));

  // R6
  ns_write_keeps_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_priv && acc_write && !acc_secure)
      |=> $stable(ctl_q[GRP_S*GRP_W +: GRP_W]));

  // R5
  ns_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_secure |-> (acc_rdata[GRP_S*GRP_W +: GRP_W] == '0));
endmodule

// File: tb/cache_ovr_ctl_test.sv
module cache_ovr_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0, acc_secure = 0, acc_priv = 0;
  logic [2:0]  acc_op1 = 0, acc_op2 = 0;
  logic [3:0]  acc_crn = 0, acc_crm = 0;
  logic [31:0] acc_wdata = 0;
  logic        acc_hit, acc_undef;
  logic [31:0] acc_rdata;
  logic        i_secure = 0, i_miss = 0, i_fill_block;
  logic        d_secure = 0, d_miss = 0, d_fill_block;
  logic [1:0]  d_attr = 0, d_attr_eff;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cache_ovr_ctl uut (.*);

  // {wr, sec, priv, enc[2:0], wdata[7:0], exp_rd[5:0], exp_undef, exp_hit}
  // enc: 0 match, 1 op1=1, 2 crn=10, 3 crm=7, 4 op2=1
  localparam int NV = 27;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h00,1'b0,1'b1},
    {1'b1,1'b1,1'b1,3'd0,8'hFF,6'h00,1'b0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h3F,1'b0,1'b1},
    {1'b0,1'b0,1'b1,3'd0,8'h00,6'h07,1'b0,1'b1},
    {1'b0,1'b1,1'b0,3'd0,8'h00,6'h00,1'b1,1'b1},
    {1'b1,1'b1,1'b0,3'd0,8'h00,6'h00,1'b1,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h3F,1'b0,1'b1},
    {1'b1,1'b0,1'b1,3'd0,8'h00,6'h00,1'b0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h38,1'b0,1'b1},
    {1'b0,1'b0,1'b1,3'd0,8'h00,6'h00,1'b0,1'b1},
    {1'b1,1'b0,1'b1,3'd0,8'h05,6'h00,1'b0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h3D,1'b0,1'b1},
    {1'b1,1'b0,1'b0,3'd0,8'h00,6'h00,1'b1,1'b1},
    {1'b0,1'b0,1'b0,3'd0,8'h00,6'h00,1'b1,1'b1},
    {1'b1,1'b1,1'b1,3'd1,8'h00,6'h00,1'b0,1'b0},
    {1'b1,1'b1,1'b1,3'd2,8'h00,6'h00,1'b0,1'b0},
    {1'b1,1'b1,1'b1,3'd3,8'h00,6'h00,1'b0,1'b0},
    {1'b1,1'b1,1'b1,3'd4,8'h00,6'h00,1'b0,1'b0},
    {1'b0,1'b1,1'b1,3'd1,8'h00,6'h00,1'b0,1'b0},
    {1'b0,1'b1,1'b1,3'd4,8'h00,6'h00,1'b0,1'b0},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h3D,1'b0,1'b1},
    {1'b1,1'b1,1'b1,3'd0,8'hCA,6'h00,1'b0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h0A,1'b0,1'b1},
    {1'b0,1'b0,1'b1,3'd0,8'h00,6'h02,1'b0,1'b1},
    {1'b1,1'b0,1'b1,3'd0,8'hFF,6'h00,1'b0,1'b1},
    {1'b0,1'b1,1'b1,3'd0,8'h00,6'h0F,1'b0,1'b1},
    {1'b0,1'b0,1'b0,3'd0,8'h00,6'h00,1'b1,1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic wr, input logic sec, input logic pr,
                       input logic [2:0] enc, input logic [7:0] wd);
    @(negedge clk);
    acc_valid  = v;
    acc_write  = wr;
    acc_secure = sec;
    acc_priv   = pr;
    acc_op1    = (enc == 3'd1) ? 3'd1 : 3'd0;
    acc_crn    = (enc == 3'd2) ? 4'd10 : 4'd9;
    acc_crm    = (enc == 3'd3) ? 4'd7 : 4'd8;
    acc_op2    = (enc == 3'd4) ? 3'd1 : 3'd0;
    acc_wdata  = {24'hA5C3E7, wd};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0;
    acc_write = 0;
    #1;
  endtask

  // R8 R9 R10 R11: full policy sweep against a known register value
  task automatic policy_sweep(input logic [5:0] s, input string ctx);
    for (int sec = 0; sec < 2; sec++) begin
      for (int at = 0; at < 4; at++) begin
        for (int m = 0; m < 2; m++) begin
          logic [2:0] grp;
          logic [1:0] eeff;
          logic       edb, eib;
          @(negedge clk);
          i_secure = sec[0]; d_secure = sec[0];
          d_attr = at[1:0]; i_miss = m[0]; d_miss = m[0];
          #1;
          grp  = sec[0] ? s[5:3] : s[2:0];
          eeff = (at[1:0] == 2'b10 && grp[2]) ? 2'b01 : at[1:0];
          edb  = m[0] && grp[0] && (at[1:0] == 2'b01 || at[1:0] == 2'b10);
          eib  = m[0] && grp[1];
          check({"R9 R8 attr ", ctx}, {30'b0, d_attr_eff}, {30'b0, eeff});
          check({"R11 dfill ", ctx}, {31'b0, d_fill_block}, {31'b0, edb});
          check({"R10 ifill ", ctx}, {31'b0, i_fill_block}, {31'b0, eib});
        end
      end
    end
  endtask

  task automatic set_reg(input logic [5:0] s);
    drive(1, 1, 1, 1, 3'd0, {2'b11, s});
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    drive(1, 0, 1, 1, 3'd0, 8'h00);
    check("R2 reset read", acc_rdata, 32'h0);
    policy_sweep(6'h00, "reset");

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [21:0] v;
      string tag;
      v = VEC[k];
      drive(1, v[21], v[20], v[19], v[18:16], v[15:8]);
      if (v[18:16] != 0)  tag = "R1";
      else if (!v[19])    tag = "R7";
      else if (!v[20])    tag = v[21] ? "R6" : "R5";
      else                tag = "R3";
      check($sformatf("%s row %0d rdata", tag, k), acc_rdata, {26'b0, v[7:2]});
      check($sformatf("%s row %0d undef", tag, k), {31'b0, acc_undef}, {31'b0, v[1]});
      check($sformatf("%s row %0d hit", tag, k), {31'b0, acc_hit}, {31'b0, v[0]});
      check($sformatf("R4 row %0d upper", k), {6'b0, acc_rdata[31:6]}, 32'h0);
    end
    // state now 0x0F

    // R1: valid low with a matching encoding
    drive(0, 1, 1, 1, 3'd0, 8'h30);
    check("R1 valid low hit", {31'b0, acc_hit}, 32'h0);
    drive(1, 0, 1, 1, 3'd0, 8'h00);
    check("R1 valid low no write", acc_rdata, 32'h0000000F);

    // R3: write visible the very next cycle, read-back zero on write cycle
    drive(1, 1, 1, 1, 3'd0, 8'h21);
    check("R3 write cycle rdata", acc_rdata, 32'h0);
    drive(1, 0, 1, 1, 3'd0, 8'h00);
    check("R3 next cycle visible", acc_rdata, 32'h00000021);
    idle();

    // policy under various register contents
    policy_sweep(6'h21, "s21");
    set_reg(6'h0A); policy_sweep(6'h0A, "s0A");
    set_reg(6'h35); policy_sweep(6'h35, "s35");
    set_reg(6'h3F); policy_sweep(6'h3F, "s3F");
    set_reg(6'h07); policy_sweep(6'h07, "s07");
    set_reg(6'h38); policy_sweep(6'h38, "s38");

    // R6: Non-secure write with secure group set, read back from Secure side
    drive(1, 1, 0, 1, 3'd0, 8'hFF);
    drive(1, 0, 1, 1, 3'd0, 8'h00);
    check("R6 ns write keeps secure", acc_rdata, 32'h0000003F);

    // R2: reset in the middle of operation
    idle();
    rst_n = 1'b0;
    #2;
    rst_n = 1'b1;
    drive(1, 0, 1, 1, 3'd0, 8'h00);
    check("R2 mid-run reset read", acc_rdata, 32'h0);
    policy_sweep(6'h00, "rst2");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule